// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a clause-22 MDIO management master operated through three memory-mapped registers on a simple register bus. Software loads a 16-bit value into the data register when it wants to write a PHY register. It then writes the command register with the PHY address, the register number, a read or write selection and the busy bit. The engine sends the serial management frame on MDC and MDIO and clears busy when the frame is over. On a read it places the bits returned by the PHY in the upper half of the data register. A one-bit status register records whether the PHY failed to pull MDIO low in the second turnaround bit of the last read.

MDC is generated from the system clock. Each half period lasts `CLK_DIV` system cycles, and MDC is held low whenever no frame is running. The engine changes its MDIO output and output enable only when MDC falls. It samples the PHY's MDIO input when MDC rises.

A control state machine orders the frame. ST_IDLE waits for a command and moves to ST_PREAMBLE when a valid command starts. ST_PREAMBLE sends the 32 ones. At the falling MDC edge after bit 31 it moves to ST_HEADER, which sends the start, opcode, PHY address and register fields (bits 32 to 45). At the falling edge after bit 45 it moves to ST_TURNAROUND (bits 46 and 47), then after bit 47 to ST_DATA (bits 48 to 63). At the falling edge after bit 63 it moves to ST_DONE, which lasts one system cycle, completes the command and returns to ST_IDLE.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command register (offset 0x3C0), the data register (offset 0x3C4) and the status register (offset 0x3D0) read 0. MDC is low and the MDIO output enable is 0.
- R2: Command register fields: bit 20 is busy, bit 17 requests a read, bit 16 requests a write, bits 12:8 hold the PHY address and bits 4:0 the register number. Writing the command register while not busy, with bit 20 set and at least one of bits 17:16 set, starts a frame. Busy then reads 1 from the next cycle until the frame ends, and reads 0 afterwards. If bit 20 is set but neither operation bit is set, no frame starts and busy stays 0.
- R3: Every frame has exactly 64 MDC rising edges. The frame bits, all sent MSB first, are 32 preamble ones, start 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address and the 5-bit register number.
- R4: In a write frame, bits 46 and 47 are the turnaround 1 then 0. Bits 48 to 63 are data register bits 15:0, MSB first. The output enable is 1 for all 64 bits.
- R5: In a read frame, the output enable is 1 for bits 0 to 45 and 0 for bits 46 to 63. The 16 MDIO input values sampled on MDC rising edges during bits 48 to 63 land in data register bits 31:16, first bit in bit 31. Data register bits 15:0 are left unchanged.
- R6: When a read completes, status bit 0 becomes the MDIO input value sampled in bit 47: 1 means invalid data, 0 means the PHY answered. A write frame leaves the status register unchanged.
- R7: Each MDC half period is CLK_DIV system clock cycles, and MDC is low whenever busy is 0. The MDIO output and output enable never change while MDC is high or rising.
- R8: Writes to the command or data register while busy is 1 are ignored. The running frame is unchanged, the stored command fields are unchanged, and no second frame follows.
- R9: A command with both bit 17 and bit 16 set runs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write access |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the engine |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench attacks the turnaround boundary of a read.

- It checks that the output enable drops at bit 46. A design that dropped it one bit late would drive against the PHY.
- It checks that the status flag follows the bit-47 value and that a later write leaves the flag alone. A design sampling the wrong bit would report a PHY that answered as failed, or a failed read as valid.

It issues a command while busy, with different fields. An engine that accepted that command would corrupt the stored fields or chain a second frame. It checks that a command with no operation bit leaves the engine idle. It checks that a command with both operation bits set produces the read opcode. It measures the MDC period, so that a divider off by one cycle shows up as a wrong edge spacing.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    localparam logic [11:0] OFS_CMD  = 12'h3C0;
    localparam logic [11:0] OFS_DATA = 12'h3C4;
    localparam logic [11:0] OFS_STAT = 12'h3D0;

    localparam int CMD_BUSY_POS = 20;
    localparam int CMD_RD_POS   = 17;
    localparam int CMD_WR_POS   = 16;
    localparam int PHY_LSB      = 8;
    localparam int FIELD_W      = 5;
    localparam int HALF_W       = 16;
    localparam int WORD_W       = 32;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int HDR_END    = 46;
    localparam int TA_END     = 48;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURNAROUND,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

    typedef struct packed {
        logic               rd;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
        logic [HALF_W-1:0]  wdata;
    } mdio_req_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick      = en && (cnt_q == CNT_LAST);
    assign rise_tick = tick && !mdc_q;
    assign fall_tick = tick && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_cmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               done,
    input  logic [HALF_W-1:0]  rd_data,
    input  logic               rd_bad,
    output logic               start,
    output mdio_req_t          req,
    output logic               busy,
    output logic [FIELD_W-1:0] cmd_phy,
    output logic [FIELD_W-1:0] cmd_regn
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic               busy_q;
    logic               rd_q;
    logic               wr_q;
    logic [FIELD_W-1:0] phy_q;
    logic [FIELD_W-1:0] regn_q;
    logic [WORD_W-1:0]  data_q;
    logic               stat_q;
    logic               cmd_wr;
    logic               data_wr;
    logic               op_any;

    assign cmd_wr  = bus_sel && bus_we && (bus_addr == A_CMD) && !busy_q;
    assign data_wr = bus_sel && bus_we && (bus_addr == A_DATA) && !busy_q;
    assign op_any  = bus_wdata[CMD_RD_POS] || bus_wdata[CMD_WR_POS];
    assign start   = cmd_wr && bus_wdata[CMD_BUSY_POS] && op_any;

    assign req.rd    = bus_wdata[CMD_RD_POS];
    assign req.phy   = bus_wdata[PHY_LSB +: FIELD_W];
    assign req.regn  = bus_wdata[FIELD_W-1:0];
    assign req.wdata = data_q[HALF_W-1:0];

    assign busy     = busy_q;
    assign cmd_phy  = phy_q;
    assign cmd_regn = regn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            phy_q  <= '0;
            regn_q <= '0;
            stat_q <= 1'b0;
        end else if (cmd_wr) begin
            busy_q <= start;
            rd_q   <= bus_wdata[CMD_RD_POS];
            wr_q   <= bus_wdata[CMD_WR_POS];
            phy_q  <= bus_wdata[PHY_LSB +: FIELD_W];
            regn_q <= bus_wdata[FIELD_W-1:0];
        end else if (done) begin
            busy_q <= 1'b0;
            if (rd_q) begin
                stat_q <= rd_bad;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= bus_wdata;
        end else if (done && rd_q) begin
            data_q[WORD_W-1:HALF_W] <= rd_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CMD) begin
            bus_rdata[CMD_BUSY_POS]          = busy_q;
            bus_rdata[CMD_RD_POS]            = rd_q;
            bus_rdata[CMD_WR_POS]            = wr_q;
            bus_rdata[PHY_LSB +: FIELD_W]    = phy_q;
            bus_rdata[FIELD_W-1:0]           = regn_q;
        end else if (bus_addr == A_DATA) begin
            bus_rdata = data_q;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[0] = stat_q;
        end
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              clk_en,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [HALF_W-1:0] rd_data,
    output logic              rd_bad
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] TA2_BIT  = BIT_W'(TA_END - 1);

    mdio_state_e            state_q, state_d;
    logic [BIT_W-1:0]       bit_q;
    logic [FRAME_BITS-1:0]  shift_q;
    logic                   rd_q;
    logic [HALF_W-1:0]      rdsh_q;
    logic                   bad_q;
    logic                   active;
    logic [FRAME_BITS-1:0]  frame_init;

    function automatic mdio_state_e phase_of(input logic [BIT_W-1:0] idx);
        if (int'(idx) < PRE_BITS)      return ST_PREAMBLE;
        else if (int'(idx) < HDR_END)  return ST_HEADER;
        else if (int'(idx) < TA_END)   return ST_TURNAROUND;
        else                           return ST_DATA;
    endfunction

    assign frame_init = {
        {PRE_BITS{1'b1}},
        2'b01,
        (req.rd ? 2'b10 : 2'b01),
        req.phy,
        req.regn,
        (req.rd ? 2'b11 : 2'b10),
        (req.rd ? {HALF_W{1'b1}} : req.wdata)
    };

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_PREAMBLE;
            end
            ST_PREAMBLE, ST_HEADER, ST_TURNAROUND, ST_DATA: begin
                if (fall_tick) begin
                    if (bit_q == LAST_BIT) state_d = ST_DONE;
                    else                   state_d = phase_of(bit_q + 1'b1);
                end
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active  = 1'b0;
        mdio_oe = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PREAMBLE, ST_HEADER: begin
                active  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_TURNAROUND, ST_DATA: begin
                active  = 1'b1;
                mdio_oe = !rd_q;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    assign clk_en  = active;
    assign mdio_o  = shift_q[FRAME_BITS-1];
    assign rd_data = rdsh_q;
    assign rd_bad  = bad_q;

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            shift_q <= '0;
            rd_q    <= 1'b0;
            rdsh_q  <= '0;
            bad_q   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                bit_q   <= '0;
                shift_q <= frame_init;
                rd_q    <= req.rd;
                bad_q   <= 1'b0;
            end
        end else if (active) begin
            if (fall_tick) begin
                bit_q   <= bit_q + 1'b1;
                shift_q <= {shift_q[FRAME_BITS-2:0], 1'b1};
            end
            if (rise_tick && rd_q) begin
                if (bit_q == TA2_BIT) bad_q <= mdio_i;
                if (state_q == ST_DATA) rdsh_q <= {rdsh_q[HALF_W-2:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic               start_w;
    mdio_req_t          req_w;
    logic               busy_w;
    logic [FIELD_W-1:0] phy_w;
    logic [FIELD_W-1:0] regn_w;
    logic               done_w;
    logic [HALF_W-1:0]  rdata_w;
    logic               rbad_w;
    logic               clk_en_w;
    logic               rise_w;
    logic               fall_w;

    mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done_w),
        .rd_data   (rdata_w),
        .rd_bad    (rbad_w),
        .start     (start_w),
        .req       (req_w),
        .busy      (busy_w),
        .cmd_phy   (phy_w),
        .cmd_regn  (regn_w)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .req       (req_w),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .mdio_i    (mdio_i),
        .clk_en    (clk_en_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done_w),
        .rd_data   (rdata_w),
        .rd_bad    (rbad_w)
    );

    mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );
endmodule

// File: rtl/mdio_cmd_checker.sv
module mdio_cmd_checker
    import mdio_cmd_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               mdc,
    input logic               mdio_o,
    input logic               mdio_oe,
    input logic               busy,
    input logic [FIELD_W-1:0] phy,
    input logic [FIELD_W-1:0] regn
);
    logic cmd_access;
    assign cmd_access = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CMD));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    p_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_access && !busy && bus_wdata[CMD_BUSY_POS] &&
         (bus_wdata[CMD_RD_POS] || bus_wdata[CMD_WR_POS])) |=> (busy && mdio_oe));

    p_no_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_access && !busy && !bus_wdata[CMD_RD_POS] && !bus_wdata[CMD_WR_POS]) |=> !busy);

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_access && busy) |=> ($stable(phy) && $stable(regn)));
endmodule

bind mdio_cmd_master mdio_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy_w),
    .phy       (phy_w),
    .regn      (regn_w)
);

// File: tb/mdio_cmd_master_bench.sv
module mdio_cmd_master_bench;
    localparam int DIV = 3;
    localparam logic [11:0] A_CMD  = 12'h3C0;
    localparam logic [11:0] A_DATA = 12'h3C4;
    localparam logic [11:0] A_STAT = 12'h3D0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_cmd_master #(.CLK_DIV(DIV), .ADDR_W(12)) u_mdio_cmd_master (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model
    int          rise_cnt = 0;
    int          fall_cnt = 0;
    logic [63:0] cap = '0;
    logic [63:0] oe_cap = '0;
    bit          phy_ack = 1'b1;
    logic [15:0] phy_val = '0;
    realtime     t_r1 = 0, t_r2 = 0;

    always @(posedge mdc) begin
        if (rise_cnt == 0) t_r1 = $realtime;
        if (rise_cnt == 1) t_r2 = $realtime;
        cap    = {cap[62:0], (mdio_oe ? mdio_o : 1'b1)};
        oe_cap = {oe_cap[62:0], mdio_oe};
        rise_cnt++;
    end

    always @(negedge mdc) begin
        fall_cnt++;
        if (fall_cnt == 47)                       mdio_i = !phy_ack;
        else if (fall_cnt >= 48 && fall_cnt <= 63) mdio_i = phy_val[63 - fall_cnt];
        else                                       mdio_i = 1'b1;
    end

    task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic prep(bit ack, logic [15:0] val);
        rise_cnt = 0; fall_cnt = 0; cap = '0; oe_cap = '0;
        mdio_i = 1'b1; phy_ack = ack; phy_val = val;
    endtask

    task automatic wait_idle(string req);
        logic [31:0] d;
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            bus_read(A_CMD, d);
            if (!d[20]) begin ok = 1; break; end
        end
        check_eq(req, "busy clears after frame", 64'(ok), 64'd1);
    endtask

    function automatic logic [45:0] hdr(logic [1:0] op, logic [4:0] phy, logic [4:0] rg);
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg};
    endfunction

    function automatic logic [31:0] cmd(bit rd, bit wr, logic [4:0] phy, logic [4:0] rg);
        return (32'(1) << 20) | (32'(rd) << 17) | (32'(wr) << 16) | (32'(phy) << 8) | 32'(rg);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_CMD, d);  check_eq("R1", "cmd after reset", 64'(d), 64'd0);
        bus_read(A_DATA, d); check_eq("R1", "data after reset", 64'(d), 64'd0);
        bus_read(A_STAT, d); check_eq("R1", "status after reset", 64'(d), 64'd0);
        check_eq("R1", "mdc/oe after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write(logic [4:0] phy, logic [4:0] rg, logic [15:0] val);
        logic [31:0] d;
        logic [31:0] st0;
        bus_read(A_STAT, st0);
        prep(1'b1, 16'h0);
        bus_write(A_DATA, {16'h0, val});
        bus_write(A_CMD, cmd(1'b0, 1'b1, phy, rg));
        bus_read(A_CMD, d);
        check_eq("R2", "busy set after write cmd", 64'(d[20]), 64'd1);
        wait_idle("R2");
        check_eq("R3", "write rising edges", 64'(rise_cnt), 64'd64);
        check_eq("R4", "write frame bits", cap, {hdr(2'b01, phy, rg), 2'b10, val});
        check_eq("R4", "write oe all bits", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(A_STAT, d);
        check_eq("R6", "status unchanged by write", 64'(d), 64'(st0));
        check_eq("R7", "mdc low when idle", 64'(mdc), 64'd0);
    endtask

    task automatic t_read(logic [4:0] phy, logic [4:0] rg, logic [15:0] val, bit ack, bit both);
        logic [31:0] d;
        bus_write(A_DATA, 32'h0000_1234);
        prep(ack, val);
        bus_write(A_CMD, cmd(1'b1, both, phy, rg));
        wait_idle("R2");
        check_eq("R3", "read rising edges", 64'(rise_cnt), 64'd64);
        check_eq(both ? "R9" : "R3", "read header bits", 64'(cap[63:18]), 64'(hdr(2'b10, phy, rg)));
        check_eq("R5", "read oe pattern", oe_cap, 64'hFFFF_FFFF_FFFC_0000);
        bus_read(A_STAT, d);
        check_eq("R6", "status after read", 64'(d), 64'(!ack));
        if (ack) begin
            bus_read(A_DATA, d);
            check_eq("R5", "read data placement", 64'(d), 64'({val, 16'h1234}));
        end
    endtask

    task automatic t_period();
        prep(1'b1, 16'h0);
        bus_write(A_CMD, cmd(1'b0, 1'b1, 5'h01, 5'h01));
        wait_idle("R7");
        check_eq("R7", "mdc period ns", 64'(int'(t_r2 - t_r1)), 64'(2 * DIV * 10));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        bus_write(A_DATA, 32'h0000_0F0F);
        prep(1'b1, 16'hBEEF);
        bus_write(A_CMD, cmd(1'b0, 1'b1, 5'h01, 5'h02));
        repeat (10) @(negedge clk);
        bus_write(A_CMD, cmd(1'b1, 1'b0, 5'h07, 5'h09));
        bus_write(A_DATA, 32'h0000_5555);
        wait_idle("R8");
        check_eq("R8", "frame unchanged by busy write", cap, {hdr(2'b01, 5'h01, 5'h02), 2'b10, 16'h0F0F});
        bus_read(A_CMD, d);
        check_eq("R8", "cmd fields kept", 64'(d), 64'(32'h0001_0102));
        bus_read(A_DATA, d);
        check_eq("R8", "data kept", 64'(d), 64'h0F0F);
        repeat (200) @(negedge clk);
        check_eq("R8", "no second frame", 64'(rise_cnt), 64'd64);
    endtask

    task automatic t_no_op();
        logic [31:0] d;
        prep(1'b1, 16'h0);
        bus_write(A_CMD, 32'h0010_0305);
        bus_read(A_CMD, d);
        check_eq("R2", "no op bit keeps busy 0", 64'(d[20]), 64'd0);
        repeat (50) @(negedge clk);
        check_eq("R2", "no op bit no frame", 64'(rise_cnt), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write(5'h0A, 5'h1F, 16'hA5C3);
        t_read(5'h13, 5'h02, 16'h6D1B, 1'b1, 1'b0);
        t_read(5'h04, 5'h11, 16'hFFFF, 1'b0, 1'b0);
        t_write(5'h1E, 5'h00, 16'h8001);
        t_read(5'h15, 5'h0A, 16'h0F81, 1'b1, 1'b1);
        t_period();
        t_busy_ignore();
        t_no_op();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule